// File: doc/BRIEF.md
# Programmable Audio Bit-Clock and Frame-Sync Generator

This block produces, for each of its channels, a bit clock and a frame-sync pulse by integer division of one of two selectable source clocks. A serial audio interface, a codec or a DAC is clocked from these outputs. Per channel, software sets a bit-clock divisor, a frame-sync divisor, a pulse-width word and a phase word through a plain write port. A single control write then enables the channel and picks its source. Both outputs start together, from a known counter state. A typical setting uses a frame divisor of 512 and a bit divisor of 8 on the same source, which gives 64 bit clocks per frame. A second channel with divisor 2 gives a master clock at 256 times the frame rate.

The design runs on one system clock. Each source input is sampled as a level, and every system-clock cycle in which the selected source is high counts as one input cycle. The frame-sync pulse is high for half the frame divisor (rounded down) unless a nonzero width word gives its length. The phase word delays the pulse within the frame. This lets the frame edge line up with the first data bit for left-justified framing, or with the bit before it for I2S.

Top module: `audio_clkgen`

## Requirements
- R1: A write selects a channel with `wrChan` and a register with `wrAddr`: 0 control, 1 frame divisor, 2 pulse width, 3 phase. In the control word, bit DATA_W-1 is the enable, bit DATA_W-2 is the source select (0 = `srcClkA`, 1 = `srcClkB`), and bits DATA_W-3..0 are the bit-clock divisor. One control write with the enable set starts both the bit clock and the frame sync of that channel.
- R2: With a bit divisor D ≥ 2, the bit clock repeats every D input cycles. It is high for floor(D/2) of them, starting high at counter value 0. Odd divisors therefore have a high phase one cycle shorter than the low phase.
- R3: A divisor of 0 or 1 makes the matching output (bit clock or frame sync) follow the selected source level directly.
- R4: With a width word of zero, the frame sync is high for floor(F/2) of each F input cycles. F is the frame divisor.
- R5: A nonzero width word W makes the frame sync high for W input cycles per frame. If W ≥ F, the frame sync stays high.
- R6: The phase word P is taken modulo F. The frame sync rises (P mod F) input cycles after the frame counter wraps to zero, so a phase of zero rises at the wrap.
- R7: The bit-clock counter restarts at every frame wrap, so the bit clock stays aligned to the frame.
- R8: While a channel is disabled, both of its outputs are low and its counters are cleared. Outputs go low two cycles after a disabling control write. After an enabling write to a disabled channel, the first output cycle shows counter value 0.
- R9: Divisor, width and phase writes take effect on an enabled channel only at the next frame wrap. On a disabled channel they take effect at once.
- R10: A control write changes the source only while the channel is fully disabled. On an enabled channel the source bit of the write is ignored. An input cycle is a system-clock cycle in which the selected source is high.
- R11: After reset, all registers are zero and all outputs are low. Enabling a channel with no other writes therefore passes the source straight through on both outputs.
- R12: Channels are independent: a disabled channel stays low while another channel runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcClkA | input | 1 | Source clock level A |
| srcClkB | input | 1 | Source clock level B |
| wrEn | input | 1 | Register write strobe |
| wrChan | input | CH_W | Channel written |
| wrAddr | input | 2 | Register written |
| wrData | input | DATA_W | Write data |
| bitClk | output | NCH | Bit clock per channel |
| frameSync | output | NCH | Frame sync per channel |

## Verification
The bench builds the block with its defaults: two channels and a 16-bit data word, which gives a 14-bit bit divisor. A 16-bit frame divisor reaches the 512-cycle frame with 64 bit clocks. With two channels, the bench can check that an idle channel stays low while the other runs the divide-by-2 master-clock setting. The source inputs are tied high and toggling, so both every-cycle and every-other-cycle counting are compared against a cycle model, along with the pass-through and saturated-width corner cases.

// File: rtl/acg_pkg.sv
package acg_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_FSDIV = 2'd1,
    REG_WIDTH = 2'd2,
    REG_PHASE = 2'd3
  } acgReg_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic run;     // channel counting, outputs live
    logic srcSel;  // 0 = source A, 1 = source B
  } acgStrobe_t;
endpackage

// File: rtl/acg_ctrl.sv
module acg_ctrl #(
  parameter int DATA_W = 16,
  localparam int DIV_W = DATA_W - 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrHit,
  input  logic [1:0]             wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  output acg_pkg::acgStrobe_t    st,
  output logic [DIV_W-1:0]       clkDivPend,
  output logic [DATA_W-1:0]      fsDivPend,
  output logic [DATA_W-1:0]      widthPend,
  output logic [DATA_W-1:0]      phasePend
);
  import acg_pkg::*;

  logic enQ;
  logic runQ;
  logic srcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ        <= 1'b0;
      runQ       <= 1'b0;
      srcQ       <= 1'b0;
      clkDivPend <= '0;
      fsDivPend  <= '0;
      widthPend  <= '0;
      phasePend  <= '0;
    end else begin
      // run lags enable by one cycle so the datapath loads the new settings first
      runQ <= enQ;
      if (wrHit) begin
        unique case (acgReg_e'(wrAddr))
          REG_CTRL: begin
            enQ        <= wrData[DATA_W-1];
            clkDivPend <= wrData[DIV_W-1:0];
            if (!enQ && !runQ) srcQ <= wrData[DATA_W-2];
          end
          REG_FSDIV: fsDivPend <= wrData;
          REG_WIDTH: widthPend <= wrData;
          REG_PHASE: phasePend <= wrData;
          default: ;
        endcase
      end
    end
  end

  assign st.run    = runQ;
  assign st.srcSel = srcQ;
endmodule

// File: rtl/acg_datapath.sv
module acg_datapath #(
  parameter int DATA_W = 16,
  localparam int DIV_W = DATA_W - 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  acg_pkg::acgStrobe_t    st,
  input  logic                   srcClkA,
  input  logic                   srcClkB,
  input  logic [DIV_W-1:0]       clkDivPend,
  input  logic [DATA_W-1:0]      fsDivPend,
  input  logic [DATA_W-1:0]      widthPend,
  input  logic [DATA_W-1:0]      phasePend,
  output logic                   bitClk,
  output logic                   frameSync
);
  localparam logic [DIV_W-1:0]  CLK_ONE = DIV_W'(1);
  localparam logic [DATA_W-1:0] FS_ONE  = DATA_W'(1);

  logic [DIV_W-1:0]  clkDivAct, bitCnt, bitHalf;
  logic [DATA_W-1:0] fsDivAct, widthAct, phaseAct, frmCnt, widthEff, phaseLoad;
  logic [DATA_W:0]   framePos;
  logic srcLvl, clkPass, fsPass, frmWrap, bitWrap, bitHigh, fsHigh;

  assign srcLvl  = st.srcSel ? srcClkB : srcClkA;
  assign clkPass = clkDivAct <= CLK_ONE;
  assign fsPass  = fsDivAct <= FS_ONE;
  assign frmWrap = srcLvl && (fsPass || frmCnt == fsDivAct - FS_ONE);
  assign bitWrap = clkPass || bitCnt == clkDivAct - CLK_ONE;

  // phase reduced once, when a new setting is taken
  assign phaseLoad = (fsDivPend <= FS_ONE) ? '0 : phasePend % fsDivPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkDivAct <= '0;
      fsDivAct  <= '0;
      widthAct  <= '0;
      phaseAct  <= '0;
      bitCnt    <= '0;
      frmCnt    <= '0;
    end else if (!st.run || frmWrap) begin
      clkDivAct <= clkDivPend;
      fsDivAct  <= fsDivPend;
      widthAct  <= widthPend;
      phaseAct  <= phaseLoad;
      bitCnt    <= '0;
      frmCnt    <= '0;
    end else if (srcLvl) begin
      frmCnt <= frmCnt + FS_ONE;
      bitCnt <= bitWrap ? '0 : bitCnt + CLK_ONE;
    end
  end

  always_comb begin
    if (frmCnt >= phaseAct) framePos = {1'b0, frmCnt - phaseAct};
    else framePos = {1'b0, frmCnt} + {1'b0, fsDivAct} - {1'b0, phaseAct};
  end

  assign widthEff = (widthAct == '0) ? (fsDivAct >> 1) : widthAct;
  assign fsHigh   = framePos < {1'b0, widthEff};
  assign bitHalf  = clkDivAct >> 1;
  assign bitHigh  = bitCnt < bitHalf;

  assign bitClk    = st.run && (clkPass ? srcLvl : bitHigh);
  assign frameSync = st.run && (fsPass ? srcLvl : fsHigh);
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int NCH    = 2,
  parameter int DATA_W = 16,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DIV_W = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcClkA,
  input  logic              srcClkB,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [NCH-1:0]    bitClk,
  output logic [NCH-1:0]    frameSync
);
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    acg_pkg::acgStrobe_t st;
    logic [DIV_W-1:0]  clkDivPend;
    logic [DATA_W-1:0] fsDivPend, widthPend, phasePend;
    logic              wrHit;

    assign wrHit = wrEn && (wrChan == CH_W'(g));

    acg_ctrl #(.DATA_W(DATA_W)) i_ctrl (
      .clk(clk), .rstN(rstN), .wrHit(wrHit), .wrAddr(wrAddr), .wrData(wrData),
      .st(st), .clkDivPend(clkDivPend), .fsDivPend(fsDivPend),
      .widthPend(widthPend), .phasePend(phasePend)
    );

    acg_datapath #(.DATA_W(DATA_W)) i_dp (
      .clk(clk), .rstN(rstN), .st(st), .srcClkA(srcClkA), .srcClkB(srcClkB),
      .clkDivPend(clkDivPend), .fsDivPend(fsDivPend), .widthPend(widthPend),
      .phasePend(phasePend), .bitClk(bitClk[g]), .frameSync(frameSync[g])
    );
  end
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
  parameter int NCH    = 2,
  parameter int DATA_W = 16,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DIV_W = DATA_W - 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [CH_W-1:0]   wrChan,
  input logic [1:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [NCH-1:0]    bitClk,
  input logic [NCH-1:0]    frameSync
);
  // R11
  reset_outputs_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (bitClk == '0 && frameSync == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic ctrlWr, enS, runS;
    assign ctrlWr = wrEn && wrChan == CH_W'(c) && wrAddr == 2'd0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enS  <= 1'b0;
        runS <= 1'b0;
      end else begin
        runS <= enS;
        if (ctrlWr) enS <= wrData[DATA_W-1];
      end
    end

    // R8
    idle_outputs_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      !runS |-> (!bitClk[c] && !frameSync[c]));

    // R8
    disable_quiets_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlWr && !wrData[DATA_W-1]) |=> ##1 (!bitClk[c] && !frameSync[c]));

    // R2
    enable_starts_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlWr && wrData[DATA_W-1] && !enS && !runS && wrData[DIV_W-1:0] > DIV_W'(1))
      |=> ##1 bitClk[c]);
  end
endmodule

bind audio_clkgen audio_clkgen_chk #(.NCH(NCH), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;
  localparam int NCH = 2;
  localparam int DATA_W = 16;
  localparam int CH_W = 1;
  localparam int DIV_W = DATA_W - 2;
  localparam int NVEC = 10;
  // src, clkDiv, fsDiv, width, phase, expected frame-sync high cycles
  localparam int VEC [NVEC][6] = '{
    '{0, 8,  64,  0,  0, 32},
    '{0, 3,  15,  0,  0,  7},
    '{0, 4,  16,  5,  3,  5},
    '{0, 4,  12,  6, 14,  6},
    '{0, 2,  10,  0,  9,  5},
    '{1, 4,  16,  0,  0,  8},
    '{0, 1,   8,  0,  0,  4},
    '{0, 8,   0,  0,  0,  1},
    '{0, 4,   8, 20,  0,  8},
    '{0, 8, 512,  0,  0, 256}
  };

  logic clk = 0, rstN = 0, srcClkA = 1, srcClkB = 0, wrEn = 0;
  logic [CH_W-1:0] wrChan = '0;
  logic [1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [NCH-1:0] bitClk, frameSync;

  int errors = 0, checks = 0;
  bit done = 0;
  int aClk = 0, aFs = 0, aPw = 0, aPh = 0, aSrc = 0;
  int pClk = 0, pFs = 0, pPw = 0, pPh = 0;
  int mb = 0, mf = 0, mCh = 0;

  always #10 clk = ~clk;
  always @(posedge clk) srcClkB <= ~srcClkB;

  audio_clkgen #(.NCH(NCH), .DATA_W(DATA_W)) i_audio_clkgen (
    .clk(clk), .rstN(rstN), .srcClkA(srcClkA), .srcClkB(srcClkB),
    .wrEn(wrEn), .wrChan(wrChan), .wrAddr(wrAddr), .wrData(wrData),
    .bitClk(bitClk), .frameSync(frameSync)
  );

  function automatic bit lvlNow();
    return aSrc != 0 ? srcClkB : srcClkA;
  endfunction

  function automatic bit expBit();
    if (aClk <= 1) return lvlNow();
    return mb < aClk / 2;
  endfunction

  function automatic bit expFs();
    int ph, pos, w;
    if (aFs <= 1) return lvlNow();
    ph  = aPh % aFs;
    pos = (mf + aFs - ph) % aFs;
    w   = (aPw == 0) ? aFs / 2 : aPw;
    return pos < w;
  endfunction

  function automatic void advance();
    if (!lvlNow()) return;
    if (aFs <= 1 || mf == aFs - 1) begin
      mf = 0; mb = 0;
      aClk = pClk; aFs = pFs; aPw = pPw; aPh = pPh;
    end else begin
      mf++;
      mb = (aClk <= 1 || mb == aClk - 1) ? 0 : mb + 1;
    end
  endfunction

  function automatic string tagOf(int i);
    case (i)
      0: return "R2 R4 R7";
      1: return "R2 R4 odd";
      2: return "R5 R6";
      3: return "R6 phase modulo";
      4: return "R6 R2";
      5: return "R10 source B";
      6: return "R3 bit pass";
      7: return "R3 frame pass";
      8: return "R5 saturated";
      default: return "R1 R7 512/8";
    endcase
  endfunction

  task automatic issue(input int ch, input int addr, input logic [DATA_W-1:0] data);
    wrChan = CH_W'(ch); wrAddr = 2'(addr); wrData = data; wrEn = 1'b1;
    if (ch == mCh) begin
      case (addr)
        0: pClk = int'(data[DIV_W-1:0]);
        1: pFs = int'(data);
        2: pPw = int'(data);
        default: pPh = int'(data);
      endcase
    end
  endtask

  task automatic wr(input int ch, input int addr, input logic [DATA_W-1:0] data);
    @(negedge clk); issue(ch, addr, data);
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input string got, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %s expected %s", tag, got, exp);
    end
  endtask

  task automatic runCycles(input int n, input int win, input string tag, output int hi);
    int bad = 0;
    string got = "", exp = "";
    bit eb, ef;
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wrEn = 1'b0;
      eb = expBit(); ef = expFs();
      if (i < win && frameSync[mCh]) hi++;
      if (bitClk[mCh] !== eb || frameSync[mCh] !== ef ||
          bitClk[1-mCh] !== 1'b0 || frameSync[1-mCh] !== 1'b0) begin
        if (bad == 0) begin
          got = $sformatf("cycle %0d bitClk=%b frameSync=%b other=%b%b", i,
                          bitClk[mCh], frameSync[mCh], bitClk[1-mCh], frameSync[1-mCh]);
          exp = $sformatf("bitClk=%b frameSync=%b other=00", eb, ef);
        end
        bad++;
      end
      advance();
    end
    check(bad == 0, tag, got, exp);
  endtask

  task automatic startChannel(input int ch, input int src, input int cd, input int fd,
                              input int pw, input int ph);
    mCh = ch;
    wr(ch, 0, {1'b0, 1'b0, DIV_W'(cd)});
    @(negedge clk);
    wr(ch, 1, DATA_W'(fd));
    wr(ch, 2, DATA_W'(pw));
    wr(ch, 3, DATA_W'(ph));
    @(negedge clk); issue(ch, 0, {1'b1, 1'(src), DIV_W'(cd)});
    @(negedge clk); wrEn = 1'b0;
    aClk = pClk; aFs = pFs; aPw = pPw; aPh = pPh; aSrc = src;
    mb = 0; mf = 0;
  endtask

  initial begin
    int hi, len, bad;
    // R11: outputs low in reset and just after
    repeat (4) @(negedge clk);
    check(bitClk == '0 && frameSync == '0, "R11 in reset",
          $sformatf("%b/%b", bitClk, frameSync), "00/00");
    rstN = 1'b1;
    @(negedge clk);
    check(bitClk == '0 && frameSync == '0, "R11 R8 after reset idle",
          $sformatf("%b/%b", bitClk, frameSync), "00/00");

    // R11 R3: enable with reset register values passes the source through
    mCh = 0;
    @(negedge clk); issue(0, 0, {1'b1, 1'b0, DIV_W'(0)});
    @(negedge clk); wrEn = 1'b0;
    aClk = 0; aFs = 0; aPw = 0; aPh = 0; aSrc = 0; mb = 0; mf = 0;
    runCycles(8, 0, "R11 R3 reset defaults", hi);

    // table of settings
    for (int v = 0; v < NVEC; v++) begin
      startChannel(0, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      len = (VEC[v][2] > 1 ? VEC[v][2] : 1) * (VEC[v][0] + 1);
      runCycles(2 * len + 8, len, tagOf(v), hi);
      check(hi == VEC[v][5] * (VEC[v][0] + 1), {tagOf(v), " high count"},
            $sformatf("%0d", hi), $sformatf("%0d", VEC[v][5] * (VEC[v][0] + 1)));
    end

    // R9: writes while running wait for the frame wrap
    startChannel(0, 0, 2, 8, 0, 0);
    runCycles(3, 0, "R9 before update", hi);
    issue(0, 1, DATA_W'(12));
    runCycles(1, 0, "R9 frame divisor write", hi);
    issue(0, 2, DATA_W'(3));
    runCycles(1, 0, "R9 width write", hi);
    issue(0, 0, {1'b1, 1'b0, DIV_W'(4)});
    runCycles(48, 0, "R9 applied at wrap", hi);

    // R10: source bit ignored while enabled
    startChannel(0, 0, 4, 16, 0, 0);
    runCycles(5, 0, "R10 before", hi);
    issue(0, 0, {1'b1, 1'b1, DIV_W'(4)});
    runCycles(48, 0, "R10 source held", hi);

    // R8: disabled outputs low, then clean restart with phase
    wr(0, 0, {1'b0, 1'b0, DIV_W'(4)});
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (bitClk != '0 || frameSync != '0) bad++;
    end
    check(bad == 0, "R8 disabled low", $sformatf("%0d bad cycles", bad), "0");
    startChannel(0, 0, 4, 16, 0, 5);
    runCycles(40, 0, "R8 R6 clean restart", hi);
    wr(0, 0, {1'b0, 1'b0, DIV_W'(4)});
    @(negedge clk);

    // R12: second channel as master clock, first channel idle
    startChannel(1, 0, 2, 512, 0, 0);
    runCycles(1100, 512, "R12 channel 1 divide by 2", hi);
    check(hi == 256, "R12 R4 channel 1 high count", $sformatf("%0d", hi), "256");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule